// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the cycle-timed controller that moves a processor core between normal (thread) execution and exception handlers. An upstream arbiter presents a request with a source number and a priority, where a smaller priority value is more urgent. On acceptance the sequencer first saves eight context words to the stack through a push strobe and an address. It then reads the handler address from a vector table at a relocatable base and pulses a start signal with that address. When the handler signals completion, the sequencer either pops the eight words back and returns to thread mode, or goes straight to the next queued handler.

Two shortcuts reduce latency. A pending request at handler completion is tail-chained: the pop and the re-push are both skipped. A more urgent request that arrives while the context is still being saved takes over the vector fetch, and the saving continues without restarting. The request it displaced is held and is tail-chained once the urgent handler finishes. A request that arrives during the return pop abandons the pop and starts its handler from the frame that is already saved. After reset the block reads the initial stack pointer from table word 0 and the reset entry address from word 4. The stack is kept at a multiple of 8 bytes by inserting one padding word when needed.

Top module: `excSeq`

## Requirements
- R1: After reset the block reads byte address 0 and then byte address 4 on the vector port (memory returns data one cycle after the address). The word from address 0, with its two low bits cleared, becomes the stack pointer. The word from address 4 appears on entryPc. handlerMode is 0 and there are no stack strobes.
- R2: A request accepted in thread mode at clock edge t gives handlerStart high in the cycle after edge t+12 when the stack pointer is a multiple of 8. Over that entry there are exactly eight push strobes with stackAddr descending from SP-4 to SP-32 in 4-byte steps.
- R3: The handler vector is read at address (vecBase with bits 1:0 cleared) + 4*number. entryPc in the handlerStart cycle equals the word returned for that address, and activeNum equals the number.
- R4: handlerMode is 1 from the first handler cycle until returnDone is seen. It is 0 in thread mode and during the save of the first frame.
- R5: handlerDone captured at edge d with nothing pending gives returnDone high in the cycle after edge d+10 (aligned frame). Over that return there are exactly eight pop strobes with stackAddr ascending from the frame base to SP-4.
- R6: handlerDone captured at edge d while a request is pending, or together with a new request, gives handlerStart for that request after edge d+6. No push or pop strobes occur between the two handlers.
- R7: A request more urgent than the one being entered, arriving before the vector read of the entry, takes over that vector read. Handler start time and the push sequence are unchanged. The displaced request is tail-chained at that handler's completion.
- R8: A request arriving during entry that is not more urgent is held pending. It does not alter the current entry and is tail-chained afterwards.
- R9: A request captured at edge r during a return pop stops the pops from that cycle and gives handlerStart after edge r+6 with no push strobes. The next return pops all eight words from the original frame base.
- R10: When the stack pointer is 4 mod 8, entry inserts one 4-byte padding step before the pushes, so handlerStart comes after edge t+13. The return adds one padding step after the pops, so returnDone comes after edge d+11. The frame base is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Exception request from the arbiter |
| reqNum | input | NUM_W | Exception number of the request |
| reqPrio | input | PRIO_W | Priority of the request, smaller is more urgent |
| handlerDone | input | 1 | Running handler has finished |
| vecBase | input | AW | Vector table base (byte address) |
| vecRdData | input | AW | Vector table word, one cycle after the address |
| vecRdEn | output | 1 | Vector table read strobe |
| vecAddr | output | AW | Vector table byte address |
| pushStrobe | output | 1 | Write one context word at stackAddr |
| popStrobe | output | 1 | Read one context word at stackAddr |
| stackAddr | output | AW | Stack byte address for the current strobe |
| handlerMode | output | 1 | 1 while an exception is active |
| handlerStart | output | 1 | One-cycle pulse in the first handler cycle |
| entryPc | output | AW | Handler (or reset) entry address |
| activeNum | output | NUM_W | Number of the exception being entered or run |
| returnDone | output | 1 | One-cycle pulse when thread mode resumes |

## Verification
A plain entry and return is repeated for every exception number from 0 to 7 under two table bases. This separates the address arithmetic from the fixed timing and the stack address ordering. A second reset with a stack pointer of 4 mod 8 separates the padded timing from the aligned timing. Two requests during entry, one more urgent and one less urgent than the current one, show whether the vector read switches and the displaced request survives. Requests placed at handler completion and in the middle of a return pop show the 6-cycle paths. The last of these also shows that the abandoned pop leaves the frame base intact.

// File: rtl/excSeqPkg.sv
package excSeqPkg;

  typedef enum logic [1:0] {
    VK_TAB = 2'd0,
    VK_SP  = 2'd1,
    VK_PC  = 2'd2
  } vecKind_e;

  typedef enum logic [2:0] {
    ST_BOOT    = 3'd0,
    ST_THREAD  = 3'd1,
    ST_ENTRY   = 3'd2,
    ST_HANDLER = 3'd3,
    ST_TAIL    = 3'd4,
    ST_EXIT    = 3'd5
  } seqState_e;

  // strobes from the control FSM to the stack/vector datapath
  typedef struct packed {
    logic     push;
    logic     pop;
    logic     spDec;
    logic     spInc;
    logic     spLoad;
    logic     spRestore;
    logic     frameSave;
    logic     pcLoad;
    logic     vecRd;
    vecKind_e vecKind;
  } seqCtl_t;

endpackage

// File: rtl/excSeqCtrl.sv
module excSeqCtrl
  import excSeqPkg::*;
#(
  parameter int NUM_W     = 6,
  parameter int PRIO_W    = 4,
  parameter int ENTRY_CYC = 12,
  parameter int TAIL_CYC  = 6,
  parameter int EXIT_CYC  = 10,
  parameter int PUSH_N    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NUM_W-1:0]  reqNum,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              handlerDone,
  input  logic              spMis,
  output seqCtl_t           ctl,
  output logic [NUM_W-1:0]  curNum,
  output logic              handlerMode,
  output logic              handlerStart,
  output logic              returnDone
);

  localparam int MAXC = ENTRY_CYC + EXIT_CYC + TAIL_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seqState_e         state;
  logic [CW-1:0]     cnt;
  logic              padFlag;
  logic [PRIO_W-1:0] curPrio;
  logic              pendValid;
  logic [NUM_W-1:0]  pendNum;
  logic [PRIO_W-1:0] pendPrio;

  logic [CW-1:0] padW, entryLast, exitLast;
  logic          lateSwap, canPend;

  assign padW      = {{(CW-1){1'b0}}, padFlag};
  assign entryLast = CW'(ENTRY_CYC - 1) + padW;
  assign exitLast  = CW'(EXIT_CYC - 1) + padW;
  assign lateSwap  = (state == ST_ENTRY) && reqValid && !pendValid &&
                     (reqPrio < curPrio) && (cnt < entryLast - CW'(1));
  assign canPend   = reqValid && !pendValid;

  assign handlerMode = (state == ST_HANDLER) || (state == ST_TAIL) || (state == ST_EXIT);

  always_comb begin
    ctl = '0;
    ctl.vecKind = VK_TAB;
    unique case (state)
      ST_BOOT: begin
        ctl.vecRd   = (cnt < CW'(2));
        ctl.vecKind = (cnt == '0) ? VK_SP : VK_PC;
        ctl.spLoad  = (cnt == CW'(1));
        ctl.pcLoad  = (cnt == CW'(2));
      end
      ST_ENTRY: begin
        ctl.push      = (cnt >= padW) && (cnt < padW + CW'(PUSH_N));
        ctl.spDec     = ctl.push || (padFlag && cnt == '0);
        ctl.vecRd     = (cnt == entryLast - CW'(1));
        ctl.pcLoad    = (cnt == entryLast);
        ctl.frameSave = (cnt == entryLast);
      end
      ST_TAIL: begin
        ctl.vecRd  = (cnt == CW'(TAIL_CYC - 2));
        ctl.pcLoad = (cnt == CW'(TAIL_CYC - 1));
      end
      ST_EXIT: begin
        ctl.pop       = (cnt < CW'(PUSH_N)) && !reqValid;
        ctl.spInc     = ctl.pop || (padFlag && cnt == CW'(PUSH_N) && !reqValid);
        ctl.spRestore = reqValid;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_BOOT;
      cnt          <= '0;
      padFlag      <= 1'b0;
      curNum       <= '0;
      curPrio      <= '0;
      pendValid    <= 1'b0;
      pendNum      <= '0;
      pendPrio     <= '0;
      handlerStart <= 1'b0;
      returnDone   <= 1'b0;
    end else begin
      handlerStart <= 1'b0;
      returnDone   <= 1'b0;
      unique case (state)
        ST_BOOT: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(2)) begin
            state <= ST_THREAD;
            cnt   <= '0;
          end
        end
        ST_THREAD: begin
          if (reqValid) begin
            state   <= ST_ENTRY;
            cnt     <= '0;
            curNum  <= reqNum;
            curPrio <= reqPrio;
            padFlag <= spMis;
          end
        end
        ST_ENTRY: begin
          cnt <= cnt + CW'(1);
          if (lateSwap) begin
            pendValid <= 1'b1;
            pendNum   <= curNum;
            pendPrio  <= curPrio;
            curNum    <= reqNum;
            curPrio   <= reqPrio;
          end else if (canPend) begin
            pendValid <= 1'b1;
            pendNum   <= reqNum;
            pendPrio  <= reqPrio;
          end
          if (cnt == entryLast) begin
            state        <= ST_HANDLER;
            cnt          <= '0;
            handlerStart <= 1'b1;
          end
        end
        ST_HANDLER: begin
          if (handlerDone) begin
            cnt <= '0;
            if (pendValid) begin
              state     <= ST_TAIL;
              curNum    <= pendNum;
              curPrio   <= pendPrio;
              pendValid <= 1'b0;
            end else if (reqValid) begin
              state   <= ST_TAIL;
              curNum  <= reqNum;
              curPrio <= reqPrio;
            end else begin
              state <= ST_EXIT;
            end
          end else if (canPend) begin
            pendValid <= 1'b1;
            pendNum   <= reqNum;
            pendPrio  <= reqPrio;
          end
        end
        ST_TAIL: begin
          cnt <= cnt + CW'(1);
          if (canPend) begin
            pendValid <= 1'b1;
            pendNum   <= reqNum;
            pendPrio  <= reqPrio;
          end
          if (cnt == CW'(TAIL_CYC - 1)) begin
            state        <= ST_HANDLER;
            cnt          <= '0;
            handlerStart <= 1'b1;
          end
        end
        ST_EXIT: begin
          if (reqValid) begin
            state   <= ST_TAIL;
            cnt     <= '0;
            curNum  <= reqNum;
            curPrio <= reqPrio;
          end else if (cnt == exitLast) begin
            state      <= ST_THREAD;
            cnt        <= '0;
            returnDone <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_BOOT;
      endcase
    end
  end

  // R4: a handler never starts outside handler mode
  p_start_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |-> handlerMode);

  // R5: a completed return always lands in thread mode
  p_ret_thread_r5: assert property (@(posedge clk) disable iff (!rstN)
    returnDone |-> !handlerMode);

  // R7: the entry target only changes mid-entry towards a more urgent request
  p_late_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && $past(state) == ST_ENTRY && curNum != $past(curNum))
      |-> (curPrio < $past(curPrio)));

endmodule

// File: rtl/excSeqData.sv
module excSeqData
  import excSeqPkg::*;
#(
  parameter int AW    = 32,
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [NUM_W-1:0] curNum,
  input  logic [AW-1:0]    vecBase,
  input  logic [AW-1:0]    vecRdData,
  output logic [AW-1:0]    vecAddr,
  output logic [AW-1:0]    stackAddr,
  output logic [AW-1:0]    entryPc,
  output logic             spMis
);

  localparam logic [AW-1:0] WORD = AW'(4);

  logic [AW-1:0] sp, frameSp, tabOff;

  assign tabOff    = AW'({curNum, 2'b00});
  assign stackAddr = ctl.spDec ? sp - WORD : sp;
  assign spMis     = sp[2];

  always_comb begin
    unique case (ctl.vecKind)
      VK_SP:   vecAddr = '0;
      VK_PC:   vecAddr = WORD;
      default: vecAddr = {vecBase[AW-1:2], 2'b00} + tabOff;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= '0;
      frameSp <= '0;
      entryPc <= '0;
    end else begin
      if (ctl.spLoad)         sp <= {vecRdData[AW-1:2], 2'b00};
      else if (ctl.spRestore) sp <= frameSp;
      else if (ctl.spDec)     sp <= sp - WORD;
      else if (ctl.spInc)     sp <= sp + WORD;
      if (ctl.frameSave) frameSp <= sp;
      if (ctl.pcLoad)    entryPc <= vecRdData;
    end
  end

  // R2: consecutive pushes walk down one word at a time
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && $past(ctl.push)) |-> (stackAddr == $past(stackAddr) - WORD));

  // R5: consecutive pops walk up one word at a time
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && $past(ctl.pop)) |-> (stackAddr == $past(stackAddr) + WORD));

  // R10: a finished frame always sits on an 8-byte boundary
  p_frame_align_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameSave |-> (sp[2:0] == 3'b000));

endmodule

// File: rtl/excSeq.sv
module excSeq
  import excSeqPkg::*;
#(
  parameter int AW        = 32,
  parameter int NUM_W     = 6,
  parameter int PRIO_W    = 4,
  parameter int ENTRY_CYC = 12,
  parameter int TAIL_CYC  = 6,
  parameter int EXIT_CYC  = 10,
  parameter int PUSH_N    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NUM_W-1:0]  reqNum,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              handlerDone,
  input  logic [AW-1:0]     vecBase,
  input  logic [AW-1:0]     vecRdData,
  output logic              vecRdEn,
  output logic [AW-1:0]     vecAddr,
  output logic              pushStrobe,
  output logic              popStrobe,
  output logic [AW-1:0]     stackAddr,
  output logic              handlerMode,
  output logic              handlerStart,
  output logic [AW-1:0]     entryPc,
  output logic [NUM_W-1:0]  activeNum,
  output logic              returnDone
);

  seqCtl_t ctl;
  logic    spMis;

  excSeqCtrl #(
    .NUM_W(NUM_W), .PRIO_W(PRIO_W), .ENTRY_CYC(ENTRY_CYC),
    .TAIL_CYC(TAIL_CYC), .EXIT_CYC(EXIT_CYC), .PUSH_N(PUSH_N)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNum(reqNum),
    .reqPrio(reqPrio), .handlerDone(handlerDone), .spMis(spMis),
    .ctl(ctl), .curNum(activeNum), .handlerMode(handlerMode),
    .handlerStart(handlerStart), .returnDone(returnDone)
  );

  excSeqData #(.AW(AW), .NUM_W(NUM_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curNum(activeNum),
    .vecBase(vecBase), .vecRdData(vecRdData), .vecAddr(vecAddr),
    .stackAddr(stackAddr), .entryPc(entryPc), .spMis(spMis)
  );

  assign vecRdEn    = ctl.vecRd;
  assign pushStrobe = ctl.push;
  assign popStrobe  = ctl.pop;

endmodule

// File: tb/sim_excSeq.sv
module sim_excSeq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RESET_PC = 32'h0000_0101;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, handlerDone = 0;
  logic [5:0] reqNum = '0;
  logic [3:0] reqPrio = '0;
  logic [31:0] vecBase = 32'h400, rdData;
  logic vecRdEn, pushStrobe, popStrobe, handlerMode, handlerStart, returnDone;
  logic [31:0] vecAddr, stackAddr, entryPc;
  logic [5:0] activeNum;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] spInit = 32'h2000;

  int pushCnt, popCnt, startCnt, startCyc, retCyc, modeBad;
  logic [31:0] firstPush, lastPush, firstPop, lastPop, startPc;
  logic [5:0] startNum;

  excSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNum(reqNum),
    .reqPrio(reqPrio), .handlerDone(handlerDone), .vecBase(vecBase),
    .vecRdData(rdData), .vecRdEn(vecRdEn), .vecAddr(vecAddr),
    .pushStrobe(pushStrobe), .popStrobe(popStrobe), .stackAddr(stackAddr),
    .handlerMode(handlerMode), .handlerStart(handlerStart), .entryPc(entryPc),
    .activeNum(activeNum), .returnDone(returnDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    if (a == 32'h0) return spInit;
    if (a == 32'h4) return RESET_PC;
    return a * 3 + 32'h11;
  endfunction

  always_ff @(posedge clk) rdData <= memf(vecAddr);
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (pushStrobe) begin
        if (pushCnt == 0) firstPush = stackAddr;
        lastPush = stackAddr;
        pushCnt++;
        if (handlerMode && startCnt == 0) modeBad++;
      end
      if (popStrobe) begin
        if (popCnt == 0) firstPop = stackAddr;
        lastPop = stackAddr;
        popCnt++;
      end
      if (handlerStart) begin
        startCnt++; startCyc = cyc; startPc = entryPc; startNum = activeNum;
      end
      if (returnDone) retCyc = cyc;
    end
  end

  task automatic clr();
    pushCnt = 0; popCnt = 0; startCnt = 0; startCyc = -1; retCyc = -1; modeBad = 0;
  endtask

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseReq(input int n, input int p, output int t);
    @(posedge clk); #1;
    reqValid = 1; reqNum = 6'(n); reqPrio = 4'(p); t = cyc + 1;
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic pulseDone(output int t);
    @(posedge clk); #1;
    handlerDone = 1; t = cyc + 1;
    @(posedge clk); #1;
    handlerDone = 0;
  endtask

  task automatic doReset(input logic [31:0] s);
    spInit = s;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  // full entry then full return, checking timing, stack and vector
  task automatic plainRound(input int n, input logic [31:0] s);
    int t, d, pad;
    logic [31:0] fb;
    pad = s[2] ? 1 : 0;
    fb = {s[31:3], 3'b000};
    clr();
    pulseReq(n, 2, t);
    repeat (16) @(posedge clk);
    @(negedge clk);
    check(startCyc - t == 12 + pad, pad ? "R10 entry latency" : "R2 entry latency", startCyc - t, 12 + pad);
    check(pushCnt == 8 && firstPush == fb - 4 && lastPush == fb - 32, "R2 push words",
          longint'(firstPush) << 8 | pushCnt, longint'(fb - 4) << 8 | 8);
    check(startPc == memf({vecBase[31:2], 2'b00} + 32'(n * 4)) && startNum == 6'(n), "R3 vector",
          startPc, memf({vecBase[31:2], 2'b00} + 32'(n * 4)));
    check(handlerMode == 1 && modeBad == 0, "R4 mode in handler", handlerMode, 1);
    pulseDone(d);
    repeat (14) @(posedge clk);
    @(negedge clk);
    check(retCyc - d == 10 + pad, pad ? "R10 return latency" : "R5 return latency", retCyc - d, 10 + pad);
    check(popCnt == 8 && firstPop == fb - 32 && lastPop == fb - 4, "R5 pop words",
          longint'(firstPop) << 8 | popCnt, longint'(fb - 32) << 8 | 8);
    check(handlerMode == 0, "R4 mode after return", handlerMode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t, d, r, t2;
    clr();
    doReset(32'h2000);
    check(entryPc == RESET_PC, "R1 reset entry", entryPc, RESET_PC);
    check(handlerMode == 0 && pushCnt == 0 && popCnt == 0, "R1 thread after reset", handlerMode, 0);

    // R3 sweep over numbers and two relocated bases
    for (int bi = 0; bi < 2; bi++) begin
      vecBase = bi ? 32'h0000_1003 : 32'h0000_0400;
      for (int n = 0; n < 8; n++) plainRound(n, 32'h2000);
    end
    vecBase = 32'h400;

    // R8: less urgent request during entry is held, then tail-chained (R6)
    clr();
    pulseReq(3, 5, t);
    repeat (3) @(posedge clk);
    pulseReq(9, 7, t2);
    repeat (12) @(posedge clk); @(negedge clk);
    check(startNum == 3 && startCyc - t == 12, "R8 entry not altered", startNum, 3);
    clr();
    pulseDone(d);
    repeat (8) @(posedge clk); @(negedge clk);
    check(startCyc - d == 6, "R6 tail latency", startCyc - d, 6);
    check(startNum == 9 && startPc == memf(32'h400 + 36), "R8 pended served", startNum, 9);
    check(pushCnt == 0 && popCnt == 0, "R6 no stack traffic", pushCnt + popCnt, 0);
    pulseDone(d);
    repeat (14) @(posedge clk); @(negedge clk);
    check(retCyc - d == 10 && popCnt == 8, "R5 return after tail", retCyc - d, 10);

    // R7: more urgent request during entry takes over the vector fetch
    clr();
    pulseReq(4, 6, t);
    repeat (1) @(posedge clk);
    pulseReq(10, 1, t2);
    repeat (14) @(posedge clk); @(negedge clk);
    check(startCyc - t == 12 && pushCnt == 8, "R7 timing kept", startCyc - t, 12);
    check(startNum == 10 && startPc == memf(32'h400 + 40), "R7 urgent vector", startNum, 10);
    clr();
    pulseDone(d);
    repeat (8) @(posedge clk); @(negedge clk);
    check(startCyc - d == 6 && startNum == 4 && pushCnt == 0, "R7 displaced tail-chained", startNum, 4);
    pulseDone(d);
    repeat (14) @(posedge clk); @(negedge clk);
    check(popCnt == 8 && retCyc - d == 10, "R7 final return", popCnt, 8);

    // R6: request together with handlerDone and nothing pending
    clr();
    pulseReq(2, 3, t);
    repeat (14) @(posedge clk);
    clr();
    @(posedge clk); #1;
    handlerDone = 1; reqValid = 1; reqNum = 6'd12; reqPrio = 4'd3; d = cyc + 1;
    @(posedge clk); #1;
    handlerDone = 0; reqValid = 0;
    repeat (8) @(posedge clk); @(negedge clk);
    check(startCyc - d == 6 && startNum == 12 && popCnt == 0, "R6 done with request", startCyc - d, 6);
    pulseDone(d);
    repeat (14) @(posedge clk); @(negedge clk);

    // R9: request during return pop abandons it
    clr();
    pulseReq(5, 2, t);
    repeat (14) @(posedge clk);
    clr();
    pulseDone(d);
    repeat (2) @(posedge clk);
    pulseReq(7, 3, r);
    repeat (8) @(posedge clk); @(negedge clk);
    check(startCyc - r == 6 && startNum == 7, "R9 abandon latency", startCyc - r, 6);
    check(popCnt == 3 && pushCnt == 0, "R9 pops stopped", popCnt, 3);
    clr();
    pulseDone(d);
    repeat (14) @(posedge clk); @(negedge clk);
    check(popCnt == 8 && firstPop == 32'h2000 - 32 && lastPop == 32'h1FFC, "R9 frame intact", firstPop, 32'h1FE0);
    check(retCyc - d == 10, "R9 return latency", retCyc - d, 10);

    // R10: misaligned stack pointer from reset
    clr();
    doReset(32'h2004);
    check(entryPc == RESET_PC, "R1 second reset", entryPc, RESET_PC);
    plainRound(6, 32'h2004);
    plainRound(1, 32'h2004);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule